// File: doc/BRIEF.md
# Exception Control and Status Word

This block forms the 32-bit word through which software sees the interrupt controller's exception state. It also turns software writes to that word into set and clear requests for the pending state of three system exceptions: the non-maskable exception, the pendable service call and the periodic tick. The prioritization engine sits outside the block. That engine provides the internal index of the exception now running, a flag saying whether that exception interrupted another one, and the internal index of the highest-priority pending exception. It also provides the pending state of each external line and of the three system exceptions.

The engine uses internal indices. Indices below 32 are the system exceptions, numbered 0 to 15. The first external line has internal index 32, and index 1023 means "none". Software uses vector numbers, and external lines start at vector 16. On the way out the block therefore subtracts 16 from any index of 32 or above, and it shows "none" as 0. The read word is combinational and follows its inputs in the same cycle. A write is a plain one-cycle strobe with data. The requests it produces come out as one-cycle pulses in the cycle after the write.

Top module: `icsr_regblk`

## Requirements
- R1: Read bits [8:0] hold the running exception's vector number. An internal index below 32 reads unchanged, an index of 32 or above reads as the index minus 16, and index 1023 reads as 0.
- R2: Read bit 11 is 1 when nothing is running (index 1023) or when the running exception interrupted no other exception. Otherwise it is 0.
- R3: Read bits [20:12] hold the highest pending exception's vector number, translated as in R1. Index 1023 gives 0.
- R4: Read bit 22 is 1 exactly when at least one external line is pending.
- R5: Read bit 31 follows NMI pending, bit 28 follows service-call pending and bit 26 follows tick pending.
- R6: A write with bit 31 set pulses `set_nmi` in the cycle after the write.
- R7: For the service call, write bit 28 pulses `set_svc` and write bit 27 pulses `clr_svc`. When both bits are 1, only `set_svc` pulses.
- R8: For the tick, write bit 26 pulses `set_tick` and write bit 25 pulses `clr_tick`. When both bits are 1, only `set_tick` pulses.
- R9: Each request is high for exactly one cycle. A cycle with no write produces no request, and write bits other than 31, 28, 27, 26 and 25 produce none either.
- R10: Read bits 9, 10, 21, 23 to 25, 27, 29 and 30 are always 0. After reset no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| act_idx | input | 10 | Internal index of the running exception (1023 = none) |
| has_preempted | input | 1 | The running exception interrupted another one |
| pend_idx | input | 10 | Internal index of the highest pending exception (1023 = none) |
| ext_pending | input | EXT_LINES | Pending state of each external line |
| nmi_pending | input | 1 | Non-maskable exception pending |
| svc_pending | input | 1 | Service call pending |
| tick_pending | input | 1 | Tick pending |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write data |
| rd_word | output | 32 | Status word |
| set_nmi | output | 1 | Request: make NMI pending |
| set_svc | output | 1 | Request: make service call pending |
| clr_svc | output | 1 | Request: clear service call pending |
| set_tick | output | 1 | Request: make tick pending |
| clr_tick | output | 1 | Request: clear tick pending |

## Verification
The assertions assume the engine only ever presents legal indices: 0 to 15 for system exceptions, 32 up to 32 + EXT_LINES - 1 for external lines, and 1023. Any other value on either index input is flagged as an input fault, not as a translation error. The stimulus walks both index inputs across every legal value, including 1023, and never presents the unused gap from 16 to 31. The write sweep drives every combination of the five command bits, and it puts varying data in the other bit positions, which must have no effect.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int IDX_W      = 10;
  localparam int VEC_W      = 9;
  localparam int WORD_W     = 32;
  localparam logic [IDX_W-1:0] NONE_IDX = '1;
  localparam int EXT_BASE   = 32;
  localparam int EXT_SHIFT  = 16;
  localparam int SYS_COUNT  = 16;
  // bit positions software depends on
  localparam int B_RETBASE  = 11;
  localparam int B_PENDVEC  = 12;
  localparam int B_EXTPEND  = 22;
  localparam int B_TICKCLR  = 25;
  localparam int B_TICKSET  = 26;
  localparam int B_SVCCLR   = 27;
  localparam int B_SVCSET   = 28;
  localparam int B_NMISET   = 31;

  typedef struct packed {
    logic nmi_set;
    logic svc_set;
    logic svc_clr;
    logic tick_set;
    logic tick_clr;
  } req_t;
endpackage

// File: rtl/icsr_vec_xlate.sv
module icsr_vec_xlate
  import icsr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  localparam logic [IDX_W-1:0] BASE  = IDX_W'(EXT_BASE);
  localparam logic [IDX_W-1:0] SHIFT = IDX_W'(EXT_SHIFT);

  logic [IDX_W-1:0] shifted;

  always_comb begin
    shifted = idx;
    if (idx >= BASE) shifted = idx - SHIFT;
    vec = (idx == NONE_IDX) ? '0 : shifted[VEC_W-1:0];
  end
endmodule

// File: rtl/icsr_cmd_decode.sv
module icsr_cmd_decode
  import icsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output req_t              req
);
  req_t nxt;

  always_comb begin
    nxt = '0;
    if (wr_en) begin
      nxt.nmi_set  = wr_data[B_NMISET];
      nxt.svc_set  = wr_data[B_SVCSET];
      nxt.svc_clr  = wr_data[B_SVCCLR] & ~wr_data[B_SVCSET];
      nxt.tick_set = wr_data[B_TICKSET];
      nxt.tick_clr = wr_data[B_TICKCLR] & ~wr_data[B_TICKSET];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= nxt;
  end

  // R6
  nmi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_NMISET]) |=> req.nmi_set);
  // R7
  svc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_SVCSET]) |=> (req.svc_set && !req.svc_clr));
  // R8
  tick_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_TICKSET]) |=> (req.tick_set && !req.tick_clr));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (req == '0));
endmodule

// File: rtl/icsr_regblk.sv
module icsr_regblk
  import icsr_pkg::*;
#(
  parameter int EXT_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [9:0]           act_idx,
  input  logic                 has_preempted,
  input  logic [9:0]           pend_idx,
  input  logic [EXT_LINES-1:0] ext_pending,
  input  logic                 nmi_pending,
  input  logic                 svc_pending,
  input  logic                 tick_pending,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_word,
  output logic                 set_nmi,
  output logic                 set_svc,
  output logic                 clr_svc,
  output logic                 set_tick,
  output logic                 clr_tick
);
  localparam int EXT_LAST = EXT_BASE + EXT_LINES - 1;

  logic [VEC_W-1:0] act_vec;
  logic [VEC_W-1:0] pend_vec;
  req_t             req;

  icsr_vec_xlate u_act_xl  (.idx(act_idx),  .vec(act_vec));
  icsr_vec_xlate u_pend_xl (.idx(pend_idx), .vec(pend_vec));

  icsr_cmd_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req     (req)
  );

  always_comb begin
    rd_word                            = '0;
    rd_word[VEC_W-1:0]                 = act_vec;
    rd_word[B_RETBASE]                 = (act_idx == NONE_IDX) | ~has_preempted;
    rd_word[B_PENDVEC +: VEC_W]        = pend_vec;
    rd_word[B_EXTPEND]                 = |ext_pending;
    rd_word[B_TICKSET]                 = tick_pending;
    rd_word[B_SVCSET]                  = svc_pending;
    rd_word[B_NMISET]                  = nmi_pending;
  end

  assign set_nmi  = req.nmi_set;
  assign set_svc  = req.svc_set;
  assign clr_svc  = req.svc_clr;
  assign set_tick = req.tick_set;
  assign clr_tick = req.tick_clr;

  // R1 input contract: only legal indices are presented
  idx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_idx < SYS_COUNT) || (act_idx == NONE_IDX) ||
     (act_idx >= EXT_BASE && act_idx <= EXT_LAST)) &&
    ((pend_idx < SYS_COUNT) || (pend_idx == NONE_IDX) ||
     (pend_idx >= EXT_BASE && pend_idx <= EXT_LAST)));
  // R1
  act_none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_idx == NONE_IDX) |-> (rd_word[VEC_W-1:0] == '0));
  // R2
  base_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_idx == NONE_IDX) |-> rd_word[B_RETBASE]);
  // R3
  pend_none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_idx == NONE_IDX) |-> (rd_word[B_PENDVEC +: VEC_W] == '0));
  // R9
  svc_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_svc && clr_svc) && !(set_tick && clr_tick));
endmodule

// File: tb/test_icsr_regblk.sv
module test_icsr_regblk;
  localparam int EXT = 64;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [9:0]     act_idx = 10'd1023;
  logic           has_preempted = 0;
  logic [9:0]     pend_idx = 10'd1023;
  logic [EXT-1:0] ext_pending = '0;
  logic           nmi_pending = 0, svc_pending = 0, tick_pending = 0;
  logic           wr_en = 0;
  logic [31:0]    wr_data = '0;
  logic [31:0]    rd_word;
  logic           set_nmi, set_svc, clr_svc, set_tick, clr_tick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  icsr_regblk #(.EXT_LINES(EXT)) i_icsr_regblk (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [9:0] legal_idx(input int k);
    if (k < 16)      return 10'(k);
    else if (k < 80) return 10'(k + 16);
    else             return 10'd1023;
  endfunction

  function automatic logic [31:0] vec_of(input logic [9:0] i);
    if (i == 10'd1023) return 0;
    if (i >= 32)       return 32'(i) - 16;
    return 32'(i);
  endfunction

  function automatic logic [31:0] exp_word(input logic [9:0] a, input logic p,
      input logic [9:0] q, input logic e, input logic n, input logic s, input logic t);
    logic [31:0] w;
    w = vec_of(a) | (vec_of(q) << 12);
    w[11] = (a == 10'd1023) || !p;
    w[22] = e; w[26] = t; w[28] = s; w[31] = n;
    return w;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset strobes", {27'd0, set_nmi, set_svc, clr_svc, set_tick, clr_tick}, 0);
    chk("R10 reset word", rd_word, 32'h0000_0800);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R10: sweep every legal index pair
    for (int a = 0; a < 81; a++) begin
      for (int q = 0; q < 81; q++) begin
        act_idx       = legal_idx(a);
        pend_idx      = legal_idx(q);
        has_preempted = q[0];
        ext_pending   = (q % 3 == 0) ? '0 : (EXT'(1) << ((a + q) % EXT));
        nmi_pending   = a[0];
        svc_pending   = q[1];
        tick_pending  = a[1] ^ q[2];
        #2;
        chk("R1 R2 R3 R4 R5 R10 word", rd_word,
            exp_word(act_idx, has_preempted, pend_idx, |ext_pending,
                     nmi_pending, svc_pending, tick_pending));
        @(negedge clk);
      end
    end

    // R6 R7 R8 R9: all command bit combinations with noise elsewhere
    for (int m = 0; m < 32; m++) begin
      logic [31:0] d;
      logic [4:0] exp_s;
      d = (32'(m) * 32'h0119_3A45) & 32'h61FF_FFFF;
      d[31] = m[4]; d[28] = m[3]; d[27] = m[2]; d[26] = m[1]; d[25] = m[0];
      exp_s = {m[4], m[3], m[2] & ~m[3], m[1], m[0] & ~m[1]};
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = ~d;
      chk("R6 R7 R8 strobes", {27'd0, set_nmi, set_svc, clr_svc, set_tick, clr_tick}, 32'(exp_s));
      @(negedge clk);
      chk("R9 one cycle", {27'd0, set_nmi, set_svc, clr_svc, set_tick, clr_tick}, 0);
    end

    // R9 write without command bits, and idle data with command bits
    wr_en = 1; wr_data = 32'h81FF_FFFF & ~32'h8000_0000;
    @(negedge clk);
    wr_en = 0; wr_data = 32'hFFFF_FFFF;
    chk("R9 no command", {27'd0, set_nmi, set_svc, clr_svc, set_tick, clr_tick}, 0);
    @(negedge clk);
    chk("R9 no write", {27'd0, set_nmi, set_svc, clr_svc, set_tick, clr_tick}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule